// File: doc/BRIEF.md
# NAND Page Hamming ECC Generator

This block sits beside the byte-wide data path of a NAND flash controller. Every byte that crosses the path is marked by a valid strobe, whether it is being written to the flash or read from it. While the engine is accumulating, it folds each such byte into a single-error-correcting Hamming code. The code has 16 line-parity bits over the byte address and 6 column-parity bits over the bit position. One code is kept for each chunk of `CHUNK_BYTES` bytes, and a page holds `NUM_CHUNKS` chunks. With the defaults, a 512-byte page yields two 3-byte codes.

Software steers the engine through a 2-bit mode value. To start a page it steps through clear, then off, then accumulate. To collect the result it steps through off, then read-out, pops three bytes per chunk through the data-register read strobe, and returns to off. Within each chunk the three code bytes come back in a fixed shuffled order. Correction is done by software that compares the stored code with the computed one.

Top module: `nand_hamming_ecc`

## Requirements
- R1: After reset `code_o` is 0xFF, and a read-out without any accumulation returns 0xFF for every code byte.
- R2: Mode 2'b11 (clear) zeroes all parity accumulators and the byte counter; with clear held for two cycles, `code_o` reads 0xFF.
- R3: In mode 2'b01 (accumulate), each byte with `dat_valid_i` high is folded into chunk number (bytes taken so far / `CHUNK_BYTES`) at in-chunk address (bytes taken so far mod `CHUNK_BYTES`); a chunk that receives no bytes reads 0xFF 0xFF 0xFF.
- R4: Line parity LP(2k+1) is the XOR of the byte parities of all bytes whose address bit k is 1, and LP(2k) covers the bytes whose address bit k is 0. Code byte 0 bit n is the inverse of LP(n), and code byte 1 bit n is the inverse of LP(8+n).
- R5: Code byte 2 bit (3+2j) is the inverse of the XOR, over all bytes, of the data bits whose bit index has bit j set; bit (2+2j) covers the indices with bit j clear (j = 0..2). Bits [1:0] of code byte 2 are always 1.
- R6: A chunk of all-0xFF bytes gives the code 0xFF 0xFF 0xFF.
- R7: In read-out, the bytes of each chunk appear in the order code byte 1, code byte 0, code byte 2, with chunks in ascending order; after the last byte of the last chunk the sequence wraps to the first.
- R8: The read pointer advances only on a `code_rd_i` cycle in mode 2'b10. `code_o` shows the new byte from the second rising edge after the strobe.
- R9: In modes 2'b00 (off) and 2'b10 (read-out), data bytes change neither the accumulators nor the byte counter.
- R10: Once `NUM_CHUNKS*CHUNK_BYTES` bytes have been taken, further bytes are ignored until the next clear.
- R11: Clear returns the read pointer to the first byte of the first chunk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Engine mode: 00 off, 01 accumulate, 10 read-out, 11 clear |
| dat_valid_i | input | 1 | A byte crosses the NAND data path this cycle |
| dat_i | input | 8 | The byte on the data path |
| code_rd_i | input | 1 | Data-register read strobe |
| code_o | output | 8 | Registered code byte at the read pointer |

## Verification
The bench builds the block with its defaults: 256-byte chunks, two chunks per page, and therefore all 16 line-parity bits. An arithmetic model in the bench covers whole and partial pages, overrun past the page end, and a sweep of 64 single-bit errors placed at scattered addresses and bit positions in an all-0xFF chunk. Together these reach every line- and column-parity bit, the read-order wrap and the clear of a half-read pointer.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  typedef enum logic [1:0] {
    ECC_OFF   = 2'b00,
    ECC_ACC   = 2'b01,
    ECC_RDOUT = 2'b10,
    ECC_CLR   = 2'b11
  } ecc_mode_e;

  localparam int BYTE_W     = 8;
  localparam int CP_W       = 6;
  localparam int CODE_BYTES = 3;
  localparam int CODE_W     = CODE_BYTES * BYTE_W;
endpackage

// File: rtl/nand_ecc_chunk_acc.sv
module nand_ecc_chunk_acc #(
  parameter int ADDR_W = 8,
  parameter int LP_W   = 2 * ADDR_W
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           clr,
  input  logic                           en,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [nand_ecc_pkg::BYTE_W-1:0] dat,
  output logic [LP_W-1:0]                lp_o,
  output logic [nand_ecc_pkg::CP_W-1:0]   cp_o
);
  import nand_ecc_pkg::*;

  logic            par;
  logic [LP_W-1:0] lp_upd;
  logic [CP_W-1:0] cp_upd;

  always_comb begin
    par = ^dat;
    lp_upd = '0;
    for (int k = 0; k < ADDR_W; k++) begin
      lp_upd[2*k]   = par & ~addr[k];
      lp_upd[2*k+1] = par & addr[k];
    end
    cp_upd = '0;
    for (int i = 0; i < BYTE_W; i++) begin
      for (int j = 0; j < CP_W/2; j++) begin
        cp_upd[2*j + ((i >> j) & 1)] = cp_upd[2*j + ((i >> j) & 1)] ^ dat[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lp_o <= '0;
      cp_o <= '0;
    end else if (en) begin
      lp_o <= lp_o ^ lp_upd;
      cp_o <= cp_o ^ cp_upd;
    end
  end
endmodule

// File: rtl/nand_ecc_rdout.sv
module nand_ecc_rdout #(
  parameter int NUM_CHUNKS = 2,
  parameter int CH_W       = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1
) (
  input  logic                                        clk,
  input  logic                                        rst,
  input  logic                                        clr,
  input  logic                                        adv,
  input  logic [NUM_CHUNKS*nand_ecc_pkg::CODE_W-1:0]  codes,
  output logic [1:0]                                  slot_o,
  output logic [nand_ecc_pkg::BYTE_W-1:0]             code_o
);
  import nand_ecc_pkg::*;

  logic [CH_W-1:0]   chunk;
  logic [CODE_W-1:0] cur;
  logic [BYTE_W-1:0] sel;

  always_comb begin
    cur = codes[int'(chunk)*CODE_W +: CODE_W];
    case (slot_o)
      2'd0:    sel = cur[2*BYTE_W-1:BYTE_W];
      2'd1:    sel = cur[BYTE_W-1:0];
      default: sel = cur[3*BYTE_W-1:2*BYTE_W];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      slot_o <= 2'd0;
      chunk  <= '0;
    end else if (adv) begin
      if (slot_o == 2'd2) begin
        slot_o <= 2'd0;
        chunk  <= (chunk == CH_W'(NUM_CHUNKS-1)) ? '0 : chunk + 1'b1;
      end else begin
        slot_o <= slot_o + 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) code_o <= '1;
    else     code_o <= sel;
  end
endmodule

// File: rtl/nand_hamming_ecc.sv
module nand_hamming_ecc #(
  parameter int CHUNK_BYTES = 256,
  parameter int NUM_CHUNKS  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_i,
  input  logic       dat_valid_i,
  input  logic [7:0] dat_i,
  input  logic       code_rd_i,
  output logic [7:0] code_o
);
  import nand_ecc_pkg::*;

  localparam int ADDR_W = $clog2(CHUNK_BYTES);
  localparam int LP_W   = 2 * ADDR_W;
  localparam int TOTAL  = CHUNK_BYTES * NUM_CHUNKS;
  localparam int CNT_W  = $clog2(TOTAL) + 1;
  localparam int SEL_W  = CNT_W - ADDR_W;

  ecc_mode_e mode;
  logic [CNT_W-1:0] byte_cnt;
  logic [SEL_W-1:0] chunk_sel;
  logic             clr, take, full;
  logic [1:0]       rd_slot;
  logic [NUM_CHUNKS*CODE_W-1:0] codes;

  assign mode      = ecc_mode_e'(mode_i);
  assign clr       = (mode == ECC_CLR);
  assign full      = (byte_cnt == CNT_W'(TOTAL));
  assign take      = dat_valid_i && (mode == ECC_ACC) && !full;
  assign chunk_sel = byte_cnt[CNT_W-1:ADDR_W];

  always_ff @(posedge clk) begin
    if (rst || clr)  byte_cnt <= '0;
    else if (take)   byte_cnt <= byte_cnt + 1'b1;
  end

  for (genvar g = 0; g < NUM_CHUNKS; g++) begin : g_chunk
    logic [LP_W-1:0] lp;
    logic [CP_W-1:0] cp;
    logic [15:0]     lp16;

    nand_ecc_chunk_acc #(.ADDR_W(ADDR_W), .LP_W(LP_W)) acc_i (
      .clk  (clk),
      .rst  (rst),
      .clr  (clr),
      .en   (take && (chunk_sel == SEL_W'(g))),
      .addr (byte_cnt[ADDR_W-1:0]),
      .dat  (dat_i),
      .lp_o (lp),
      .cp_o (cp)
    );

    always_comb begin
      lp16 = '0;
      lp16[LP_W-1:0] = lp;
    end

    assign codes[g*CODE_W +: CODE_W] = {~cp, 2'b11, ~lp16[15:8], ~lp16[7:0]};
  end

  nand_ecc_rdout #(.NUM_CHUNKS(NUM_CHUNKS)) rd_i (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .adv    (code_rd_i && (mode == ECC_RDOUT)),
    .codes  (codes),
    .slot_o (rd_slot),
    .code_o (code_o)
  );
endmodule

// File: rtl/nand_hamming_ecc_chk.sv
module nand_hamming_ecc_chk #(
  parameter int CNT_W = 10,
  parameter int TOTAL = 512
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode_i,
  input logic             code_rd_i,
  input logic [7:0]       code_o,
  input logic [CNT_W-1:0] byte_cnt,
  input logic [1:0]       rd_slot
);
  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b11 && $past(mode_i) == 2'b11 && !$past(rst)) |=> code_o == 8'hFF); // R2
  AST_OFF_FREEZES: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b00 && $past(mode_i) == 2'b00 && !$past(rst)) |=> $stable(code_o)); // R9
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b00 || mode_i == 2'b10) |=> $stable(byte_cnt)); // R9
  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    byte_cnt <= CNT_W'(TOTAL)); // R10
  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b10 && code_rd_i && rd_slot != 2'd2) |=> rd_slot == $past(rd_slot) + 2'd1); // R8
  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!(mode_i == 2'b10 && code_rd_i) && mode_i != 2'b11) |=> $stable(rd_slot)); // R8
  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'b10 && code_rd_i && rd_slot == 2'd2) |=> rd_slot == 2'd0); // R7
endmodule

bind nand_hamming_ecc nand_hamming_ecc_chk #(.CNT_W(CNT_W), .TOTAL(TOTAL)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .mode_i    (mode_i),
  .code_rd_i (code_rd_i),
  .code_o    (code_o),
  .byte_cnt  (byte_cnt),
  .rd_slot   (rd_slot)
);

// File: tb/nand_hamming_ecc_tb.sv
module nand_hamming_ecc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CHUNK      = 256;
  localparam int NCH        = 2;
  localparam int PAGE       = CHUNK * NCH;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       dv = 1'b0;
  logic [7:0] dat = 8'h00;
  logic       rd = 1'b0;
  logic [7:0] code_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] mem [0:PAGE-1];

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_hamming_ecc #(.CHUNK_BYTES(CHUNK), .NUM_CHUNKS(NCH)) dut_i (
    .clk(clk), .rst(rst), .mode_i(mode), .dat_valid_i(dv), .dat_i(dat),
    .code_rd_i(rd), .code_o(code_o)
  );

  function automatic logic [23:0] model(int c, int n);
    logic [15:0] lp = '0;
    logic [5:0]  cp = '0;
    for (int j = 0; j < CHUNK; j++) begin
      int a = c * CHUNK + j;
      if (a < n) begin
        logic [7:0] b = mem[a];
        if (^b) begin
          for (int k = 0; k < 8; k++) begin
            if ((j >> k) & 1) lp[2*k+1] = ~lp[2*k+1];
            else              lp[2*k]   = ~lp[2*k];
          end
        end
        for (int i = 0; i < 8; i++)
          if (b[i])
            for (int q = 0; q < 3; q++) cp[2*q + ((i >> q) & 1)] = ~cp[2*q + ((i >> q) & 1)];
      end
    end
    return {~cp, 2'b11, ~lp[15:8], ~lp[7:0]};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic set_mode(logic [1:0] m);
    mode = m;
    @(negedge clk);
  endtask

  task automatic enable();
    set_mode(2'b11); set_mode(2'b00); set_mode(2'b01);
  endtask

  task automatic feed(int n);
    for (int i = 0; i < n; i++) begin
      dv = 1'b1; dat = mem[i];
      @(negedge clk);
    end
    dv = 1'b0;
  endtask

  task automatic feed_junk(int n, logic [7:0] v);
    for (int i = 0; i < n; i++) begin
      dv = 1'b1; dat = v ^ 8'(i);
      @(negedge clk);
    end
    dv = 1'b0;
  endtask

  task automatic read_one(output logic [7:0] v);
    v = code_o;
    rd = 1'b1; @(negedge clk);
    rd = 1'b0; @(negedge clk);
  endtask

  // expects the sequence starting at the first byte of the first chunk
  task automatic expect_page(string req, int nbytes, int nread);
    for (int k = 0; k < nread; k++) begin
      logic [23:0] cd = model((k / 3) % NCH, nbytes);
      logic [7:0]  e, a;
      case (k % 3)
        0: e = cd[15:8];
        1: e = cd[7:0];
        default: e = cd[23:16];
      endcase
      read_one(a);
      chk(req, a, e);
    end
  endtask

  task automatic to_read();
    set_mode(2'b00); set_mode(2'b10); @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset code_o", code_o, 8'hFF);
    for (int i = 0; i < PAGE; i++) mem[i] = 8'hFF;
    to_read();
    expect_page("R1 read after reset", 0, 6);
    set_mode(2'b00);

    // R6 all-FF page
    enable(); feed(PAGE); to_read();
    expect_page("R6 all-FF page", PAGE, 6);
    // R7 wrap to first byte
    expect_page("R7 wrap after last chunk", PAGE, 3);
    set_mode(2'b00);

    // R3 R4 R5 R7 patterned page
    for (int i = 0; i < PAGE; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
    enable(); feed(PAGE); to_read();
    expect_page("R4 R5 R7 pattern page", PAGE, 6);

    // R9 bytes ignored in off and read-out; R8 strobe ignored outside read-out
    set_mode(2'b00);
    feed_junk(20, 8'h5A);
    rd = 1'b1; repeat (3) @(negedge clk); rd = 1'b0;
    set_mode(2'b10);
    feed_junk(20, 8'hC3);
    @(negedge clk);
    expect_page("R8 R9 ignored bytes and strobes", PAGE, 6);
    set_mode(2'b00);

    // R10 overrun past page end
    enable(); feed(PAGE); feed_junk(40, 8'h17); to_read();
    expect_page("R10 overrun ignored", PAGE, 6);
    set_mode(2'b00);

    // R11 R2 clear resets pointer mid-read
    enable(); feed(PAGE); to_read();
    expect_page("R7 partial read", PAGE, 2);
    set_mode(2'b11);
    set_mode(2'b11);
    chk("R2 clear gives FF", code_o, 8'hFF);
    set_mode(2'b00); set_mode(2'b01); feed(PAGE); to_read();
    expect_page("R11 pointer restarted", PAGE, 6);
    set_mode(2'b00);

    // R3 partial page: chunk1 untouched
    for (int i = 0; i < PAGE; i++) mem[i] = 8'(i * 13 + 5);
    enable(); feed(100); to_read();
    expect_page("R3 partial page", 100, 6);
    set_mode(2'b00);

    // R4 R5 single-bit error sweep in chunk 0
    for (int i = 0; i < PAGE; i++) mem[i] = 8'hFF;
    for (int t = 0; t < 64; t++) begin
      int a = (t * 37 + t / 8) % CHUNK;
      int b = t % 8;
      mem[a] = mem[a] ^ (8'h01 << b);
      enable(); feed(CHUNK); to_read();
      expect_page("R4 R5 single-bit sweep", CHUNK, 3);
      set_mode(2'b00);
      mem[a] = 8'hFF;
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule